// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives the six switches of a three-phase inverter bridge. One 16-bit carrier counter runs up and down between the dead-time value and a programmed period. Each of the three phases compares the carrier against its own active compare value and turns that into a high-side and a low-side output. A dead-time stage holds back every turn-on, so the two switches of one leg are never on at once and always see a guard interval between them.

Software writes new compare values into per-phase buffers. A buffer is copied into the working compare only at the carrier trough, or optionally at the peak as well, so a pulse is never cut part-way through a half-cycle. The count clock is the system clock divided by a selectable power of four. Peak and trough interrupt pulses can be masked one at a time. A converter start pulse follows a chosen reference point after a programmable number of count-clock ticks.

A register write port (address, data, write enable) sets up the block. All state changes on the rising clock edge. Reset is synchronous and active high. The period must be larger than the dead time.

Top module: `cpwm_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every phase output, both interrupt pulses and the converter trigger are low and the carrier is zero. Reset clears every buffer-pending flag and sets every working compare and buffer to 0xFFFF. If the block is started with no duty writes, every phase stays at 0% (low side on for the whole carrier cycle).
- R2: The clock-select field (control register, address 0, bits 3:1) picks a count-clock divide of 1, 4, 16, 64, 256 or 1024 for codes 0 to 5. Codes 6 and 7 also give 1024. The spacing between consecutive peak pulses is 2*(PERIOD-DEAD)*divide clock cycles.
- R3: While the run bit (address 0, bit 0) is set, the carrier rises by one per count tick from DEAD (address 2) to PERIOD (address 1), then falls by one back to DEAD, and repeats. The carrier changes only on count ticks. While the run bit is clear, the carrier rests at DEAD, all outputs are low, and no peak or trough pulse occurs. A peak pulse and a trough pulse never occur together.
- R4: The high-side and low-side outputs of one phase are never high in the same cycle.
- R5: Each turn-on of either output of a phase comes at least DEAD count ticks after the other output of that phase turned off.
- R6: With working compare C and DEAD < C < PERIOD, the high side is on while the carrier is above C, less the dead time. Over one carrier cycle the high side is on for 2*(PERIOD-C)-1-DEAD ticks and the low side for 2*(C-DEAD)+1-DEAD ticks.
- R7: A working compare of 0 gives 100% duty: the high side is on for the whole cycle and the low side never turns on. A working compare at or above PERIOD gives 0% duty: the low side is on for the whole cycle and the high side never turns on.
- R8: A write to a duty buffer (addresses 4, 5 and 6 for phases 0, 1 and 2) has no effect on the outputs until the next trough. When the load-at-peak bit (address 0, bit 6) is set, the copy also happens at the peak.
- R9: A peak pulse on irq_peak appears one cycle after the peak tick only when bit 4 of address 0 is set. A trough pulse on irq_trough appears one cycle after the trough tick only when bit 5 is set. Each enable acts alone.
- R10: adc_trig pulses for one cycle DELAY count ticks (address 3) after the reference point's interrupt pulse. The reference point is the trough when bit 7 of address 0 is clear and the peak when it is set. DELAY 0 makes the trigger coincide with that interrupt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_hi | output | 3 | High-side output per phase, active high |
| pwm_lo | output | 3 | Low-side output per phase, active high |
| irq_peak | output | 1 | One-cycle pulse at the carrier peak |
| irq_trough | output | 1 | One-cycle pulse at the carrier trough |
| adc_trig | output | 1 | One-cycle converter start pulse |

## Verification
The hardest case to reach from the ports is a duty write that lands between a trough and the next load point. Telling the two load policies apart needs a write inside one half-cycle and a measurement window placed so that only one policy predicts the count seen. The bench waits for the trough pulse, writes at once, then counts high-side cycles over one carrier length, starting either just after that trough or just after the following peak. Each window is placed so that both of its edges fall where the output does not depend on the compare. Random period, dead-time and duty sets then check the on-time formulas. The slowest divide is checked with a very short period so that peak-to-peak timing stays within the run limit.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    localparam int CNT_W   = 16;
    localparam int NUM_PH  = 3;
    localparam int ADDR_W  = 3;
    localparam int PRESC_W = 10;

    localparam int A_CTRL   = 0;
    localparam int A_PERIOD = 1;
    localparam int A_DEAD   = 2;
    localparam int A_ADCDLY = 3;
    localparam int A_DUTY0  = 4;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic       adc_at_peak;
        logic       load_peak;
        logic       trough_ie;
        logic       peak_ie;
        logic [2:0] clk_sel;
        logic       run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic peak;
        logic trough;
    } evt_t;

    function automatic logic [PRESC_W-1:0] presc_last(input logic [2:0] sel);
        logic [PRESC_W-1:0] r;
        case (sel)
            3'd0:    r = PRESC_W'(0);
            3'd1:    r = PRESC_W'(3);
            3'd2:    r = PRESC_W'(15);
            3'd3:    r = PRESC_W'(63);
            3'd4:    r = PRESC_W'(255);
            default: r = PRESC_W'(1023);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler #(
    parameter int PW = cpwm_pkg::PRESC_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PW-1:0] pcnt_q;
    logic [PW-1:0] last;

    always_comb begin
        last = cpwm_pkg::presc_last(sel);
        tick = (pcnt_q >= last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cpwm_carrier.sv
module cpwm_carrier #(
    parameter int CW = cpwm_pkg::CNT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 tick,
    input  logic [CW-1:0]        period,
    input  logic [CW-1:0]        floor_v,
    output logic [CW-1:0]        cnt,
    output cpwm_pkg::evt_t       evt
);
    import cpwm_pkg::*;

    dir_e dir_q;

    always_comb begin
        evt.peak   = run && tick && (dir_q == DIR_UP)   && (cnt >= period);
        evt.trough = run && tick && (dir_q == DIR_DOWN) && (cnt <= floor_v);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            dir_q <= DIR_UP;
        end else if (!run) begin
            cnt   <= floor_v;
            dir_q <= DIR_UP;
        end else if (tick) begin
            if (dir_q == DIR_UP) begin
                if (cnt >= period) begin
                    dir_q <= DIR_DOWN;
                    cnt   <= cnt - 1'b1;
                end else begin
                    cnt   <= cnt + 1'b1;
                end
            end else begin
                if (cnt <= floor_v) begin
                    dir_q <= DIR_UP;
                    cnt   <= cnt + 1'b1;
                end else begin
                    cnt   <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
    parameter int CW = cpwm_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic          raw,
    input  logic [CW-1:0] dead,
    output logic          hi,
    output logic          lo
);
    logic          side_q;
    logic [CW-1:0] hold_q;
    logic          settled;

    always_comb begin
        settled = (hold_q == '0);
        hi      = run &&  side_q && settled;
        lo      = run && !side_q && settled;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            side_q <= 1'b0;
            hold_q <= '0;
        end else if (!run) begin
            side_q <= 1'b0;
            hold_q <= dead;
        end else if (tick) begin
            if (raw != side_q) begin
                side_q <= raw;
                hold_q <= dead;
            end else if (!settled) begin
                hold_q <= hold_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpwm_adc_trig.sv
module cpwm_adc_trig #(
    parameter int CW = cpwm_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          ref_evt,
    input  logic [CW-1:0] delay,
    output logic          trig
);
    logic          pend_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            left_q <= '0;
            trig   <= 1'b0;
        end else begin
            trig <= 1'b0;
            if (ref_evt) begin
                if (delay == '0) begin
                    trig   <= 1'b1;
                    pend_q <= 1'b0;
                end else begin
                    pend_q <= 1'b1;
                    left_q <= delay - 1'b1;
                end
            end else if (tick && pend_q) begin
                if (left_q == '0) begin
                    trig   <= 1'b1;
                    pend_q <= 1'b0;
                end else begin
                    left_q <= left_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top #(
    parameter int CW  = cpwm_pkg::CNT_W,
    parameter int NPH = cpwm_pkg::NUM_PH,
    parameter int AW  = cpwm_pkg::ADDR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    output logic [NPH-1:0] pwm_hi,
    output logic [NPH-1:0] pwm_lo,
    output logic           irq_peak,
    output logic           irq_trough,
    output logic           adc_trig
);
    import cpwm_pkg::*;

    localparam logic [AW-1:0] ADR_CTRL   = AW'(A_CTRL);
    localparam logic [AW-1:0] ADR_PERIOD = AW'(A_PERIOD);
    localparam logic [AW-1:0] ADR_DEAD   = AW'(A_DEAD);
    localparam logic [AW-1:0] ADR_ADCDLY = AW'(A_ADCDLY);
    localparam logic [CW-1:0] CMP_RESET  = '1;

    ctrl_t         ctrl_q;
    logic [CW-1:0] period_q;
    logic [CW-1:0] dt_q;
    logic [CW-1:0] adc_dly_q;

    logic          run_w;
    logic          peak_ie_w;
    logic          tick_w;
    logic [CW-1:0] cnt_w;
    evt_t          evt_w;
    logic          load_evt;
    logic          adc_ref;

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            period_q  <= '0;
            dt_q      <= '0;
            adc_dly_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_CTRL:   ctrl_q    <= ctrl_t'(wr_data[CTRL_W-1:0]);
                ADR_PERIOD: period_q  <= wr_data;
                ADR_DEAD:   dt_q      <= wr_data;
                ADR_ADCDLY: adc_dly_q <= wr_data;
                default:    ;
            endcase
        end
    end

    always_comb begin
        run_w     = ctrl_q.run;
        peak_ie_w = ctrl_q.peak_ie;
        load_evt  = evt_w.trough || (ctrl_q.load_peak && evt_w.peak);
        adc_ref   = ctrl_q.adc_at_peak ? evt_w.peak : evt_w.trough;
    end

    cpwm_prescaler #(.PW(PRESC_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .sel  (ctrl_q.clk_sel),
        .tick (tick_w)
    );

    cpwm_carrier #(.CW(CW)) u_carrier (
        .clk     (clk),
        .rst     (rst),
        .run     (run_w),
        .tick    (tick_w),
        .period  (period_q),
        .floor_v (dt_q),
        .cnt     (cnt_w),
        .evt     (evt_w)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        localparam logic [AW-1:0] ADR_DUTY = AW'(A_DUTY0 + p);

        logic [CW-1:0] buf_q;
        logic [CW-1:0] act_q;
        logic          pend_q;
        logic          hit;
        logic          raw;

        always_comb begin
            hit = wr_en && (wr_addr == ADR_DUTY);
            // compare 0 forces full on; compare at or above period never exceeded
            raw = (act_q == '0) || ((act_q < period_q) && (cnt_w > act_q));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                buf_q  <= CMP_RESET;
                act_q  <= CMP_RESET;
                pend_q <= 1'b0;
            end else begin
                if (load_evt && pend_q) begin
                    act_q  <= buf_q;
                    pend_q <= 1'b0;
                end
                if (hit) begin
                    buf_q  <= wr_data;
                    pend_q <= 1'b1;
                end
            end
        end

        cpwm_deadband #(.CW(CW)) u_db (
            .clk  (clk),
            .rst  (rst),
            .run  (run_w),
            .tick (tick_w),
            .raw  (raw),
            .dead (dt_q),
            .hi   (pwm_hi[p]),
            .lo   (pwm_lo[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_peak   <= 1'b0;
            irq_trough <= 1'b0;
        end else begin
            irq_peak   <= evt_w.peak   && ctrl_q.peak_ie;
            irq_trough <= evt_w.trough && ctrl_q.trough_ie;
        end
    end

    cpwm_adc_trig #(.CW(CW)) u_adc (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_w),
        .ref_evt (adc_ref),
        .delay   (adc_dly_q),
        .trig    (adc_trig)
    );
endmodule

// File: rtl/cpwm_checker.sv
module cpwm_checker #(
    parameter int CW  = cpwm_pkg::CNT_W,
    parameter int NPH = cpwm_pkg::NUM_PH
) (
    input logic           clk,
    input logic           rst,
    input logic           run,
    input logic           tick,
    input logic           peak_ie,
    input logic [CW-1:0]  cnt,
    input logic [CW-1:0]  dead,
    input logic [NPH-1:0] hi,
    input logic [NPH-1:0] lo,
    input logic           irq_peak,
    input logic           irq_trough,
    input logic           adc_trig
);
    // R1: first cycle after reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hi == '0 && lo == '0 && cnt == '0 && !irq_peak && !irq_trough && !adc_trig));

    // R3: carrier moves only on count ticks
    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && !$past(tick)) |-> $stable(cnt));

    // R3: peak and trough pulses are exclusive
    a_r3_single_event: assert property (@(posedge clk) disable iff (rst)
        !(irq_peak && irq_trough));

    // R9: masked peak pulse stays low
    a_r9_peak_masked: assert property (@(posedge clk) disable iff (rst)
        !$past(peak_ie) |-> !irq_peak);

    for (genvar p = 0; p < NPH; p++) begin : g_chk
        // R4: complementary pair never both on
        a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
            !(hi[p] && lo[p]));

        // R5: with dead time, high side never turns on straight from low side
        a_r5_gap_hi: assert property (@(posedge clk) disable iff (rst)
            ($rose(hi[p]) && $past(dead) != '0) |-> !$past(lo[p]));

        // R5: same for the low side
        a_r5_gap_lo: assert property (@(posedge clk) disable iff (rst)
            ($rose(lo[p]) && $past(dead) != '0) |-> !$past(hi[p]));
    end
endmodule

bind cpwm_top cpwm_checker #(.CW(CW), .NPH(NPH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run_w),
    .tick       (tick_w),
    .peak_ie    (peak_ie_w),
    .cnt        (cnt_w),
    .dead       (dt_q),
    .hi         (pwm_hi),
    .lo         (pwm_lo),
    .irq_peak   (irq_peak),
    .irq_trough (irq_trough),
    .adc_trig   (adc_trig)
);

// File: tb/cpwm_top_test.sv
module cpwm_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  pwm_hi;
    logic [2:0]  pwm_lo;
    logic        irq_peak;
    logic        irq_trough;
    logic        adc_trig;

    int checks = 0;
    int errors = 0;
    int cfg_dt = 0;
    int cfg_div = 1;
    int mh[3];
    int ml[3];
    int mpk;
    int mtr;
    int low_run[3];
    logic [2:0] prev_hi = '0;
    logic [2:0] prev_lo = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cpwm_top uut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pwm_hi     (pwm_hi),
        .pwm_lo     (pwm_lo),
        .irq_peak   (irq_peak),
        .irq_trough (irq_trough),
        .adc_trig   (adc_trig)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int carrier_len(input int p, input int dt);
        return 2 * (p - dt);
    endfunction
    function automatic int exp_hi(input int p, input int c, input int dt);
        return 2 * (p - c) - 1 - dt;
    endfunction
    function automatic int exp_lo(input int c, input int dt);
        return 2 * (c - dt) + 1 - dt;
    endfunction
    function automatic logic [15:0] mkctrl(input bit run, input int sel, input bit pie,
                                           input bit tie, input bit lp, input bit ap);
        return {8'h00, ap, lp, tie, pie, sel[2:0], run};
    endfunction

    // R4 / R5 monitor at the ports
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 3; i++) begin
                if (pwm_hi[i] && pwm_lo[i]) begin
                    checks++; errors++;
                    $display("FAIL R4 phase %0d overlap actual 1 expected 0", i);
                end
                if ((pwm_hi[i] && !prev_hi[i]) || (pwm_lo[i] && !prev_lo[i]))
                    check(low_run[i] >= cfg_dt * cfg_div, "R5 dead gap", low_run[i], cfg_dt * cfg_div);
                if (!pwm_hi[i] && !pwm_lo[i]) low_run[i]++;
                else low_run[i] = 0;
            end
        end else begin
            for (int i = 0; i < 3; i++) low_run[i] = 100000;
        end
        prev_hi = pwm_hi;
        prev_lo = pwm_lo;
    end

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input int p, input int dt, input int sel, input int adcd);
        wr(0, 16'h0000);
        wr(1, p[15:0]);
        wr(2, dt[15:0]);
        wr(3, adcd[15:0]);
        cfg_dt = dt;
        cfg_div = (sel >= 5) ? 1024 : (1 << (2 * sel));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic measure(input int n);
        for (int i = 0; i < 3; i++) begin mh[i] = 0; ml[i] = 0; end
        mpk = 0; mtr = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            for (int i = 0; i < 3; i++) begin
                mh[i] += int'(pwm_hi[i]);
                ml[i] += int'(pwm_lo[i]);
            end
            mpk += int'(irq_peak);
            mtr += int'(irq_trough);
        end
    endtask

    task automatic wait_trough();
        do @(negedge clk); while (!irq_trough);
    endtask
    task automatic wait_peak();
        do @(negedge clk); while (!irq_peak);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual 1 expected 0");
        finish_run();
    end

    initial begin
        int L;
        int n;
        void'($urandom(32'd4242));
        idle(5);
        check(pwm_hi == 3'b000 && pwm_lo == 3'b000, "R1 outputs in reset", {pwm_hi, pwm_lo}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(pwm_hi == 3'b000 && pwm_lo == 3'b000, "R1 outputs after reset", {pwm_hi, pwm_lo}, 0);
        check(!irq_peak && !irq_trough && !adc_trig, "R1 pulses after reset",
              {irq_peak, irq_trough, adc_trig}, 0);

        // R1: no duty written -> all phases at 0%
        setup(50, 3, 0, 0);
        wr(0, mkctrl(1, 0, 1, 1, 1, 0));
        L = carrier_len(50, 3);
        idle(3 * L);
        measure(L);
        for (int i = 0; i < 3; i++) begin
            check(mh[i] == 0, "R1 reset compare hi", mh[i], 0);
            check(ml[i] == L, "R1 reset compare lo", ml[i], L);
        end

        // R6 directed duty
        setup(60, 4, 0, 0);
        wr(4, 16'd20); wr(5, 16'd30); wr(6, 16'd45);
        wr(0, mkctrl(1, 0, 1, 1, 1, 0));
        L = carrier_len(60, 4);
        idle(3 * L);
        measure(L);
        check(mh[0] == exp_hi(60, 20, 4), "R6 hi ph0", mh[0], exp_hi(60, 20, 4));
        check(ml[1] == exp_lo(30, 4), "R6 lo ph1", ml[1], exp_lo(30, 4));
        check(mh[2] == exp_hi(60, 45, 4), "R6 hi ph2", mh[2], exp_hi(60, 45, 4));
        check(mpk == 1 && mtr == 1, "R3 one peak and trough per cycle", mpk * 10 + mtr, 11);

        // R7 full on / full off, entered while running
        wr(4, 16'd0); wr(5, 16'hFFFF); wr(6, 16'd60);
        idle(3 * L);
        measure(L);
        check(mh[0] == L && ml[0] == 0, "R7 100% phase 0", mh[0] * 1000 + ml[0], L * 1000);
        check(mh[1] == 0 && ml[1] == L, "R7 0% phase 1", mh[1] * 1000 + ml[1], L);
        check(mh[2] == 0 && ml[2] == L, "R7 0% at period phase 2", mh[2] * 1000 + ml[2], L);

        // R8 trough-only load
        wr(4, 16'd20);
        wr(0, mkctrl(1, 0, 1, 1, 0, 0));
        idle(3 * L);
        wait_trough();
        wr(4, 16'd40);
        idle(2);
        measure(L);
        check(mh[0] == exp_hi(60, 20, 4), "R8 old duty kept until trough", mh[0], exp_hi(60, 20, 4));
        measure(L);
        check(mh[0] == exp_hi(60, 40, 4), "R8 new duty after trough", mh[0], exp_hi(60, 40, 4));

        // R8 load at peak as well
        wr(0, mkctrl(1, 0, 1, 1, 1, 0));
        wait_trough();
        wr(4, 16'd25);
        wait_peak();
        idle(3);
        measure(L);
        check(mh[0] == exp_hi(60, 25, 4), "R8 duty loaded at peak", mh[0], exp_hi(60, 25, 4));

        // R9 independent interrupt masks
        wr(0, mkctrl(1, 0, 0, 1, 1, 0));
        idle(4);
        measure(2 * L);
        check(mpk == 0, "R9 peak masked", mpk, 0);
        check(mtr == 2, "R9 trough enabled", mtr, 2);
        wr(0, mkctrl(1, 0, 1, 0, 1, 0));
        idle(4);
        measure(2 * L);
        check(mpk == 2, "R9 peak enabled", mpk, 2);
        check(mtr == 0, "R9 trough masked", mtr, 0);

        // R10 converter trigger delay
        wr(3, 16'd5);
        wr(0, mkctrl(1, 0, 1, 1, 1, 0));
        wait_trough();
        n = 0;
        do begin @(negedge clk); n++; end while (!adc_trig && n < 1000);
        check(n == 5, "R10 trough delay", n, 5);
        wr(3, 16'd9);
        wr(0, mkctrl(1, 0, 1, 1, 1, 1));
        wait_peak();
        wait_peak();
        n = 0;
        do begin @(negedge clk); n++; end while (!adc_trig && n < 1000);
        check(n == 9, "R10 peak delay", n, 9);
        wr(3, 16'd0);
        wait_peak();
        wait_peak();
        check(adc_trig == 1'b1, "R10 zero delay coincides", adc_trig, 1);

        // R3 stopped
        wr(0, mkctrl(0, 0, 1, 1, 1, 0));
        idle(2);
        measure(300);
        check(mpk == 0 && mtr == 0, "R3 no events when stopped", mpk + mtr, 0);
        check(mh[0] + ml[0] + mh[1] + ml[1] + mh[2] + ml[2] == 0, "R3 outputs low when stopped",
              mh[0] + ml[0], 0);

        // R2 / R3 carrier timing at several divides
        setup(40, 2, 0, 0);
        wr(0, mkctrl(1, 0, 1, 1, 1, 0));
        wait_peak();
        n = 0;
        do begin @(negedge clk); n++; end while (!irq_peak && n < 100000);
        check(n == carrier_len(40, 2), "R3 peak spacing div 1", n, carrier_len(40, 2));
        setup(40, 2, 2, 0);
        wr(0, mkctrl(1, 2, 1, 1, 1, 0));
        wait_peak();
        n = 0;
        do begin @(negedge clk); n++; end while (!irq_peak && n < 100000);
        check(n == carrier_len(40, 2) * 16, "R2 peak spacing div 16", n, carrier_len(40, 2) * 16);
        setup(6, 1, 5, 0);
        wr(0, mkctrl(1, 5, 1, 1, 1, 0));
        wait_peak();
        n = 0;
        do begin @(negedge clk); n++; end while (!irq_peak && n < 100000);
        check(n == carrier_len(6, 1) * 1024, "R2 peak spacing div 1024", n, carrier_len(6, 1) * 1024);

        // R6 random trials
        for (int t = 0; t < 16; t++) begin
            int p;
            int dt;
            int c[3];
            p  = 40 + int'($urandom % 80);
            dt = int'($urandom % 6);
            setup(p, dt, 0, 0);
            for (int i = 0; i < 3; i++) begin
                c[i] = (2 * dt + 4) + int'($urandom % (p - 3 * dt - 7));
                wr(4 + i, c[i][15:0]);
            end
            wr(0, mkctrl(1, 0, 1, 1, 1, 0));
            L = carrier_len(p, dt);
            idle(3 * L);
            measure(L);
            for (int i = 0; i < 3; i++) begin
                check(mh[i] == exp_hi(p, c[i], dt), "R6 random hi", mh[i], exp_hi(p, c[i], dt));
                check(ml[i] == exp_lo(c[i], dt), "R6 random lo", ml[i], exp_lo(c[i], dt));
            end
        end

        finish_run();
    end
endmodule